// File: doc/BRIEF.md
# Serial Flash Bitstream Loader

This block is a single-lane SPI master that pulls a configuration image out of a serial flash after a one-cycle start request. On start it captures a read-style select and a 24-bit flash address, drops chip select and runs a divided serial clock. It sends a read command, the address and, for the fast variant, one byte of dummy clocks. After that it only listens.

The incoming bit stream is searched bit by bit for a sync pattern, so the image may begin at any bit offset. The 32-bit word after the sync pattern gives the number of 32-bit payload words. Each payload byte is presented on a byte port with a one-cycle strobe. A CRC-32 is accumulated over the payload bits, and the word that follows the payload is compared with it. The block then raises either a success flag or an error flag, ends the clocking and releases chip select.

Top module: `bsl_loader`

## Requirements
- R1: A one-cycle `start` while idle latches `fast_sel` and `boot_addr` and drives `spi_csn` low on the next cycle. `spi_csn` stays low until the falling serial clock edge that follows the last bit of the CRC word, and then returns high.
- R2: While a transfer runs, `spi_sclk` has a period of DIV system clocks (DIV even, default 4). It is low whenever `spi_csn` is high.
- R3: The first 8 bits on `spi_mosi`, MSB first, are the command: 0x03 when `fast_sel`=0 and 0x0B when `fast_sel`=1. `spi_mosi` changes only on falling `spi_sclk` edges while chip select is low.
- R4: The 24 bits after the command carry the latched `boot_addr`, MSB first.
- R5: With `fast_sel`=1, eight dummy clocks (MOSI low) follow the address before data is taken; with `fast_sel`=0 there are none. `spi_miso` is sampled on rising `spi_sclk` edges.
- R6: Bits received before the sync word (default 0xAA995566) are discarded. The match is tested after every received bit, so the sync word may begin at any bit offset.
- R7: The 32-bit word after the sync word is a count N of payload words. Exactly 4·N bytes are output on `pay_byte`, MSB first, each with a one-cycle `pay_valid` that occurs only while `spi_csn` is low. N=0 outputs no byte.
- R8: The CRC is computed MSB first with polynomial 0x04C11DB7, initial value 0xFFFFFFFF, no reflection and no final XOR, over the payload bits in arrival order. It is compared with the 32-bit word after the payload. A match sets `done`; a mismatch sets `error`. The two flags are never high together.
- R9: Reset gives `spi_csn`=1, `spi_sclk`=0, `spi_mosi`=0, `done`=0, `error`=0, `pay_valid`=0. A new start clears `done` and `error`; otherwise they hold their value.
- R10: `start` has no effect while a transfer is in progress. After the transfer ends, chip select stays high.
- R11: The number of rising serial clock edges while chip select is low equals header bits (32 or 40), plus the pre-sync bits, plus 96, plus 32·N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request |
| fast_sel | input | 1 | 1 selects fast read with dummy byte |
| boot_addr | input | 24 | Flash start address |
| spi_miso | input | 1 | Serial data from flash |
| spi_csn | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| pay_byte | output | 8 | Payload byte |
| pay_valid | output | 1 | One-cycle strobe for `pay_byte` |
| done | output | 1 | Image received with matching CRC |
| error | output | 1 | CRC mismatch |

## Verification
The assertions rely on `start` being a single-cycle pulse. They also rely on `spi_miso` changing only on falling serial clock edges, so that it is stable at each rising edge where it is sampled. The behavioural flash in the bench meets this: it changes its data only on falling edges and counts command bits on rising edges. Every image it serves holds a sync word, and it clears the area before the sync word to zeros so that no false match can occur. Payload counts stay small, so every transfer ends well inside the run.

// File: rtl/bsl_pkg.sv
`timescale 1ns/1ps
package bsl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HUNT,
        ST_LEN,
        ST_PAY,
        ST_CRC,
        ST_STOP
    } ld_state_e;

    localparam logic [7:0]  OPC_READ  = 8'h03;
    localparam logic [7:0]  OPC_FAST  = 8'h0B;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;
    localparam int          WORD_W    = 32;

    typedef struct packed {
        logic [7:0]  opc;
        logic [23:0] addr;
        logic [7:0]  pad;
    } hdr_t;

    function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic b);
        return {c[30:0], 1'b0} ^ (((c[31] ^ b) == 1'b1) ? CRC_POLY : 32'h0);
    endfunction

    function automatic logic [5:0] hdr_bits(input logic fast);
        return fast ? 6'd40 : 6'd32;
    endfunction

endpackage

// File: rtl/bsl_sclk_gen.sv
`timescale 1ns/1ps
module bsl_sclk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_tk,
    output logic fall_tk
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term    = run && (cnt == CW'(HALF - 1));
    assign rise_tk = term && !sclk;
    assign fall_tk = term && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (term) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R2: a stopped generator leaves the clock low
    assert_sclk_stop_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk);

endmodule

// File: rtl/bsl_crc32.sv
`timescale 1ns/1ps
module bsl_crc32 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic        bit_i,
    output logic [31:0] crc_o
);
    import bsl_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc_o <= CRC_INIT;
        else if (en)
            crc_o <= crc_bit(crc_o, bit_i);
    end

endmodule

// File: rtl/bsl_loader.sv
`timescale 1ns/1ps
module bsl_loader #(
    parameter int          DIV       = 4,
    parameter logic [31:0] SYNC_WORD = 32'hAA99_5566
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        fast_sel,
    input  logic [23:0] boot_addr,
    input  logic        spi_miso,
    output logic        spi_csn,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic [7:0]  pay_byte,
    output logic        pay_valid,
    output logic        done,
    output logic        error
);
    import bsl_pkg::*;

    localparam int HDR_W  = $bits(hdr_t);
    localparam int BIT_CW = $clog2(WORD_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(WORD_W - 1);

    ld_state_e          state;
    logic [HDR_W-1:0]   hdr_sr;
    logic [5:0]         hdr_len;
    logic [5:0]         hdr_cnt;
    logic [WORD_W-1:0]  win;
    logic [WORD_W-1:0]  rx_next;
    logic [BIT_CW-1:0]  bit_cnt;
    logic [WORD_W-1:0]  words_left;
    logic [31:0]        crc_q;
    logic               rise_tk, fall_tk, run;
    hdr_t               hdr_new;

    assign run      = (state != ST_IDLE);
    assign rx_next  = {win[WORD_W-2:0], spi_miso};
    assign spi_mosi = hdr_sr[HDR_W-1];

    always_comb begin
        hdr_new.opc  = fast_sel ? OPC_FAST : OPC_READ;
        hdr_new.addr = boot_addr;
        hdr_new.pad  = 8'h00;
    end

    bsl_sclk_gen #(.DIV(DIV)) u_clk (
        .clk(clk), .rst(rst), .run(run),
        .sclk(spi_sclk), .rise_tk(rise_tk), .fall_tk(fall_tk)
    );

    bsl_crc32 u_crc (
        .clk(clk), .rst(rst),
        .clr(state == ST_IDLE && start),
        .en(state == ST_PAY && rise_tk),
        .bit_i(spi_miso),
        .crc_o(crc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            hdr_sr     <= '0;
            hdr_len    <= 6'd32;
            hdr_cnt    <= '0;
            win        <= '0;
            bit_cnt    <= '0;
            words_left <= '0;
            spi_csn    <= 1'b1;
            pay_byte   <= '0;
            pay_valid  <= 1'b0;
            done       <= 1'b0;
            error      <= 1'b0;
        end else begin
            pay_valid <= 1'b0;
            if (state != ST_IDLE && fall_tk)
                hdr_sr <= {hdr_sr[HDR_W-2:0], 1'b0};
            if (rise_tk && state != ST_HDR && state != ST_STOP)
                win <= rx_next;
            unique case (state)
                ST_IDLE: if (start) begin
                    hdr_sr  <= hdr_new;
                    hdr_len <= hdr_bits(fast_sel);
                    hdr_cnt <= '0;
                    win     <= '0;
                    spi_csn <= 1'b0;
                    done    <= 1'b0;
                    error   <= 1'b0;
                    state   <= ST_HDR;
                end
                ST_HDR: if (rise_tk) begin
                    hdr_cnt <= hdr_cnt + 1'b1;
                    if (hdr_cnt == hdr_len - 6'd1)
                        state <= ST_HUNT;
                end
                ST_HUNT: if (rise_tk && rx_next == SYNC_WORD) begin
                    bit_cnt <= '0;
                    state   <= ST_LEN;
                end
                ST_LEN: if (rise_tk) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        words_left <= rx_next;
                        state      <= (rx_next == '0) ? ST_CRC : ST_PAY;
                    end
                end
                ST_PAY: if (rise_tk) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt[2:0] == 3'd7) begin
                        pay_byte  <= rx_next[7:0];
                        pay_valid <= 1'b1;
                    end
                    if (bit_cnt == LAST_BIT) begin
                        words_left <= words_left - 1'b1;
                        if (words_left == 1)
                            state <= ST_CRC;
                    end
                end
                ST_CRC: if (rise_tk) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        done  <= (rx_next == crc_q);
                        error <= (rx_next != crc_q);
                        state <= ST_STOP;
                    end
                end
                ST_STOP: if (fall_tk) begin
                    spi_csn <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: serial clock idles low with chip select released
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> !spi_sclk);

    // R3: MOSI holds while the serial clock stays high
    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R7: payload strobes only inside a transfer
    assert_byte_in_xfer_R7: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> !spi_csn);

    // R8: success and failure never together
    assert_flag_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R10: a start during the header or data phases keeps the transfer running
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (start && state != ST_IDLE && state != ST_STOP) |=> !spi_csn);

endmodule

// File: tb/bsl_loader_tb_top.sv
`timescale 1ns/1ps
module bsl_loader_tb_top;

    localparam int          DIV  = 4;
    localparam logic [31:0] SYNC = 32'hAA99_5566;
    localparam int          NB   = 2048;

    typedef struct packed {
        logic        fast;
        logic [23:0] addr;
        logic [7:0]  pre;
        logic [7:0]  nwords;
        logic        bad;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h000000, 8'd0,  8'd2, 1'b0},
        '{1'b1, 24'h000010, 8'd13, 8'd3, 1'b0},
        '{1'b0, 24'hC30020, 8'd5,  8'd0, 1'b0},
        '{1'b1, 24'h000008, 8'd7,  8'd1, 1'b1},
        '{1'b1, 24'h000000, 8'd31, 8'd4, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic fast_sel = 1'b0;
    logic [23:0] boot_addr = '0;
    logic spi_miso = 1'b0;
    logic spi_csn, spi_sclk, spi_mosi, pay_valid, done, error;
    logic [7:0] pay_byte;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bsl_loader #(.DIV(DIV), .SYNC_WORD(SYNC)) dut_i (
        .clk(clk), .rst(rst), .start(start), .fast_sel(fast_sel),
        .boot_addr(boot_addr), .spi_miso(spi_miso), .spi_csn(spi_csn),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .pay_byte(pay_byte),
        .pay_valid(pay_valid), .done(done), .error(error)
    );

    // behavioural flash
    logic       fbits [NB];
    int         rcnt = 0;
    logic [7:0] f_op = '0;
    logic [23:0] f_addr = '0;
    logic       sclk_prev = 1'b0;
    time        rise_t [4];

    always @(spi_sclk, spi_csn) begin
        if (spi_csn) begin
            rcnt = 0;
        end else if (spi_sclk && !sclk_prev) begin
            if (rcnt < 8) f_op = {f_op[6:0], spi_mosi};
            else if (rcnt < 32) f_addr = {f_addr[22:0], spi_mosi};
            if (rcnt < 4) rise_t[rcnt] = $time;
            rcnt = rcnt + 1;
        end else if (!spi_sclk && sclk_prev) begin
            if (rcnt >= ((f_op == 8'h0B) ? 40 : 32))
                spi_miso = fbits[(int'(f_addr) * 8 + rcnt - ((f_op == 8'h0B) ? 40 : 32)) % NB];
        end
        sclk_prev = spi_sclk;
    end

    // byte monitor
    logic [7:0] rx [1024];
    int rx_n = 0;
    always @(negedge clk) if (pay_valid) begin
        rx[rx_n] = pay_byte;
        rx_n = rx_n + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pword(input int i, input int v);
        return 32'h1234_5678 ^ (32'(i) * 32'h9E37_79B9) ^ (32'(v) << 8);
    endfunction

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r = c;
        for (int b = 31; b >= 0; b--)
            r = {r[30:0], 1'b0} ^ (((r[31] ^ w[b]) == 1'b1) ? 32'h04C1_1DB7 : 32'h0);
        return r;
    endfunction

    task automatic put_word(input int base, inout int k, input logic [31:0] w);
        for (int b = 31; b >= 0; b--) begin
            fbits[(base + k) % NB] = w[b];
            k++;
        end
    endtask

    task automatic build(input vec_t v, input int vi);
        int base = int'(v.addr) * 8;
        int k = 0;
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < NB; i++) fbits[i] = 1'b0;
        k = int'(v.pre);
        put_word(base, k, SYNC);
        put_word(base, k, 32'(v.nwords));
        for (int i = 0; i < int'(v.nwords); i++) begin
            put_word(base, k, pword(i, vi));
            c = crc_upd(c, pword(i, vi));
        end
        put_word(base, k, v.bad ? (c ^ 32'h0000_0100) : c);
    endtask

    task automatic pulse_start(input logic fs, input logic [23:0] a);
        @(negedge clk);
        fast_sel = fs; boot_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int vi, input bit poke);
        int base_n;
        int exp_r;
        build(v, vi);
        base_n = rx_n;
        pulse_start(v.fast, v.addr);
        chk(spi_csn == 1'b0, "R1 csn low after start", spi_csn, 0);
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && error == 1'b0, "R9 flags cleared by start", {done, error}, 0);
        if (poke) begin
            repeat (150) @(negedge clk);
            pulse_start(~v.fast, 24'h00FF00); // R10: must be ignored
        end
        wait (spi_csn == 1'b1);
        repeat (2) @(negedge clk);
        exp_r = (v.fast ? 40 : 32) + int'(v.pre) + 96 + 32 * int'(v.nwords);
        chk(f_op == (v.fast ? 8'h0B : 8'h03), "R3 command", f_op, v.fast ? 8'h0B : 8'h03);
        chk(f_addr == v.addr, "R4 address", f_addr, v.addr);
        chk(rcnt == 0 && spi_sclk == 1'b0, "R2 idle clock low", spi_sclk, 0);
        chk(rx_n - base_n == 4 * int'(v.nwords), "R7 byte count", rx_n - base_n, 4 * int'(v.nwords));
        for (int i = 0; i < int'(v.nwords); i++)
            for (int j = 0; j < 4; j++)
                if (base_n + 4 * i + j < rx_n)
                    chk(rx[base_n + 4 * i + j] == pword(i, vi)[31 - 8 * j -: 8], "R6 R7 payload byte",
                        rx[base_n + 4 * i + j], pword(i, vi)[31 - 8 * j -: 8]);
        chk(done == !v.bad && error == v.bad, "R8 result flags", {done, error}, {!v.bad, v.bad});
        exp_r = exp_r; // R5 R11: rise count includes dummy byte for fast read
        chk(last_rises == exp_r, "R5 R11 clock count", last_rises, exp_r);
    endtask

    // rising edges seen during the last chip-select-low window
    int last_rises = 0;
    int cur_rises = 0;
    always @(negedge clk) begin
        if (!spi_csn && spi_sclk && !prev_sclk_c) cur_rises = cur_rises + 1;
        if (spi_csn && !prev_csn_c) begin
            last_rises = cur_rises;
            cur_rises = 0;
        end
        prev_sclk_c = spi_sclk;
        prev_csn_c = spi_csn;
    end
    logic prev_sclk_c = 1'b0;
    logic prev_csn_c = 1'b1;

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_csn == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R9 reset pins",
            {spi_csn, spi_sclk, spi_mosi}, 3'b100);
        chk(done == 1'b0 && error == 1'b0 && pay_valid == 1'b0, "R9 reset flags",
            {done, error, pay_valid}, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i, 1'b0);
            if (i == 0)
                chk(rise_t[2] - rise_t[1] == DIV * 4, "R2 sclk period",
                    rise_t[2] - rise_t[1], DIV * 4);
        end

        // R10: start pulse mid-transfer has no effect
        run_vec(VECS[1], 7, 1'b1);
        repeat (40) @(negedge clk);
        chk(spi_csn == 1'b1, "R10 no restart after ignored start", spi_csn, 1);
        chk(done == 1'b1, "R10 flags held after ignored start", done, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule